// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block sits between a small CPU core and its byte-wide memory bus and carries out the fixed hardware steps that move the CPU from an accepted interrupt request to its first handler fetch. The CPU raises `req_valid` at an instruction boundary, or at a suspension point of a long string or repeat instruction. The sequencer then captures the flag register, the program counter and the stack pointer. From that point it drives the bus and the register write ports on a fixed 20-cycle schedule.

Over the 20 cycles it does the following:
- reads the interrupt information from addresses 0 and 1,
- asks the request logic to clear the pending bit of that source,
- clears the interrupt-enable, single-step and stack-select flags,
- pushes the saved flags and PC as four bytes in a fixed, non-sequential order,
- reads a three-byte handler address from the vector table,
- loads the new priority level, and finally writes the PC and the stack pointer together.

The flag register is 16 bits:
- D (single-step) is bit 2.
- I (interrupt enable) is bit 6.
- U (stack select) is bit 7.
- The priority level field occupies bits 14:12.

Every bus access takes one clock. Read data is sampled at the end of the read cycle.

Top module: `int_entry_seq`

## Requirements
- R1: When idle and `req_valid` is high, `req_ack` is high in that same cycle. Flags, PC and SP are captured on that edge, and sequence cycle 0 follows on the next cycle.
- R2: In cycle 0 the block reads address 0 and takes the interrupt number from `bus_rdata[5:0]`. In cycle 1 it reads address 1 and takes the level from `bus_rdata[2:0]`. All other data bits are ignored.
- R3: In cycle 2 `clr_req` pulses for one cycle, and `clr_num` carries the interrupt number read in cycle 0.
- R4: In cycle 2 `flg_we` writes the captured flags with bits 2 and 6 cleared. Bit 7 is also cleared, unless `sw_int` was high with `sw_num` in 32..63, in which case bit 7 keeps its captured value.
- R5: Cycles 6 to 9 are byte writes to SP-2, SP-1, SP-4 and SP-3, in that order, using 16-bit stack arithmetic. The bytes written are:
  - SP-2 receives flags[7:0].
  - SP-1 receives {flags[15:12], PC[19:16]}.
  - SP-4 receives PC[7:0].
  - SP-3 receives PC[15:8].
  All flag and PC values here are the captured ones.
- R6: Cycles 12 to 14 read addresses V, V+1 and V+2, where V = VEC_BASE + 4 × interrupt number.
- R7: In cycle 15 `flg_we` writes the R4 value with bits 14:12 replaced by the level.
- R8: In cycle 19 `done`, `pc_we` and `sp_we` are high for that single cycle. `pc_out` = {byte2[3:0], byte1, byte0} of the vector, and `sp_out` = SP-4.
- R9: Cycles 3-5, 10-11 and 16-18 carry no read, write or flag write. `bus_rd` and `bus_wr` are never high together.
- R10: While a sequence runs, `req_ack` stays low. Changes on `req_valid`, `flg_in`, `pc_in`, `sp_in`, `sw_int` and `sw_num` have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Acknowledged request ready at an instruction boundary |
| sw_int | input | 1 | Entry comes from a software interrupt instruction |
| sw_num | input | 6 | Software interrupt number |
| flg_in | input | 16 | Current flag register |
| pc_in | input | 20 | Current program counter (return address) |
| sp_in | input | 16 | Current stack pointer |
| req_ack | output | 1 | Request accepted this cycle |
| bus_addr | output | 20 | Bus address |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data |
| clr_req | output | 1 | Clear pending bit of the source |
| clr_num | output | 6 | Source number to clear |
| flg_we | output | 1 | Flag register write enable |
| flg_out | output | 16 | New flag value |
| pc_we | output | 1 | PC write enable |
| pc_out | output | 20 | Handler start address |
| sp_we | output | 1 | Stack pointer write enable |
| sp_out | output | 16 | New stack pointer |
| done | output | 1 | Sequence complete |

## Verification
The embedded assertions check four properties on every cycle:
- the read and write strobes never overlap,
- `done` is a single-cycle pulse,
- an acceptance is always followed by the information read at address 0,
- the first stack write lands at SP-2 and the PC load comes five cycles after a vector read.

The bench scenarios cover the properties that need cycle-exact schedules and data values:
- the push byte contents under wrapping stack pointers,
- the U-flag exception at the 31/32 and 63 software-number boundaries,
- masking of the unused information bits,
- vector assembly,
- the idle gaps,
- input changes during a busy sequence having no effect.

// File: rtl/int_entry_seq.sv
module int_entry_seq #(
  parameter logic [19:0] VEC_BASE = 20'h0FD00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        sw_int,
  input  logic [5:0]  sw_num,
  input  logic [15:0] flg_in,
  input  logic [19:0] pc_in,
  input  logic [15:0] sp_in,
  output logic        req_ack,
  output logic [19:0] bus_addr,
  output logic        bus_rd,
  output logic        bus_wr,
  output logic [7:0]  bus_wdata,
  input  logic [7:0]  bus_rdata,
  output logic        clr_req,
  output logic [5:0]  clr_num,
  output logic        flg_we,
  output logic [15:0] flg_out,
  output logic        pc_we,
  output logic [19:0] pc_out,
  output logic        sp_we,
  output logic [15:0] sp_out,
  output logic        done
);
  localparam logic [4:0]  LAST   = 5'd19;
  localparam logic [15:0] F_D    = 16'h0004;
  localparam logic [15:0] F_I    = 16'h0040;
  localparam logic [15:0] F_U    = 16'h0080;

  logic        busy, keep_u;
  logic [4:0]  cnt;
  logic [5:0]  num;
  logic [2:0]  lvl;
  logic [15:0] flg_s, sp_s, flg_clr;
  logic [19:0] pc_s, vec, vec_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; cnt <= '0; keep_u <= 1'b0; num <= '0; lvl <= '0;
      flg_s <= '0; pc_s <= '0; sp_s <= '0; vec <= '0;
    end else if (!busy) begin
      if (req_valid) begin
        busy   <= 1'b1;
        cnt    <= '0;
        flg_s  <= flg_in;
        pc_s   <= pc_in;
        sp_s   <= sp_in;
        keep_u <= sw_int && sw_num[5];
      end
    end else begin
      cnt <= cnt + 5'd1;
      if (cnt == LAST) busy <= 1'b0;
      case (cnt)
        5'd0:  num         <= bus_rdata[5:0];
        5'd1:  lvl         <= bus_rdata[2:0];
        5'd12: vec[7:0]    <= bus_rdata;
        5'd13: vec[15:8]   <= bus_rdata;
        5'd14: vec[19:16]  <= bus_rdata[3:0];
        default: ;
      endcase
    end
  end

  wire ph_info = busy && (cnt < 5'd2);
  wire ph_push = busy && (cnt >= 5'd6) && (cnt <= 5'd9);
  wire ph_vec  = busy && (cnt >= 5'd12) && (cnt <= 5'd14);

  assign req_ack  = !busy && req_valid;
  assign bus_rd   = ph_info || ph_vec;
  assign bus_wr   = ph_push;
  assign vec_addr = VEC_BASE + {12'd0, num, 2'b00};
  assign flg_clr  = flg_s & ~(F_D | F_I | (keep_u ? 16'h0000 : F_U));
  assign flg_out  = (busy && cnt == 5'd15) ? {flg_clr[15], lvl, flg_clr[11:0]} : flg_clr;
  assign flg_we   = busy && (cnt == 5'd2 || cnt == 5'd15);
  assign clr_req  = busy && cnt == 5'd2;
  assign clr_num  = num;
  assign done     = busy && cnt == LAST;
  assign pc_we    = done;
  assign sp_we    = done;
  assign pc_out   = vec;
  assign sp_out   = sp_s - 16'd4;

  always_comb begin
    bus_addr  = '0;
    bus_wdata = '0;
    case (cnt)
      5'd1:  bus_addr = 20'd1;
      5'd6:  begin bus_addr = {4'h0, sp_s - 16'd2}; bus_wdata = flg_s[7:0]; end
      5'd7:  begin bus_addr = {4'h0, sp_s - 16'd1}; bus_wdata = {flg_s[15:12], pc_s[19:16]}; end
      5'd8:  begin bus_addr = {4'h0, sp_s - 16'd4}; bus_wdata = pc_s[7:0]; end
      5'd9:  begin bus_addr = {4'h0, sp_s - 16'd3}; bus_wdata = pc_s[15:8]; end
      5'd12: bus_addr = vec_addr;
      5'd13: bus_addr = vec_addr + 20'd1;
      5'd14: bus_addr = vec_addr + 20'd2;
      default: ;
    endcase
    if (!busy) begin
      bus_addr  = '0;
      bus_wdata = '0;
    end
  end

  a_r9_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r2_first_read: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> (bus_rd && bus_addr == 20'd0));
  a_r5_first_push: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !$past(bus_wr)) |-> (bus_addr == {4'h0, sp_s - 16'd2}));
  a_r8_vec_then_load: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |-> $past(bus_rd, 5));
endmodule

// File: tb/test_int_entry_seq.sv
`timescale 1ns/1ps
module test_int_entry_seq;
  localparam logic [19:0] VB = 20'h0FD00;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, sw_int = 1'b0;
  logic [5:0] sw_num = '0;
  logic [15:0] flg_in = '0, sp_in = '0;
  logic [19:0] pc_in = '0;
  logic req_ack, bus_rd, bus_wr, clr_req, flg_we, pc_we, sp_we, done;
  logic [19:0] bus_addr, pc_out;
  logic [7:0] bus_wdata, bus_rdata;
  logic [5:0] clr_num;
  logic [15:0] flg_out, sp_out;
  logic [5:0] m_num = '0;
  logic [2:0] m_lvl = '0;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  int_entry_seq #(.VEC_BASE(VB)) i_int_entry_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .sw_int(sw_int), .sw_num(sw_num),
    .flg_in(flg_in), .pc_in(pc_in), .sp_in(sp_in), .req_ack(req_ack),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .clr_req(clr_req), .clr_num(clr_num), .flg_we(flg_we),
    .flg_out(flg_out), .pc_we(pc_we), .pc_out(pc_out), .sp_we(sp_we), .sp_out(sp_out),
    .done(done));

  function automatic logic [7:0] vbyte(input logic [19:0] a);
    return (a[7:0] ^ {a[11:8], a[15:12]}) + 8'h3C;
  endfunction

  always_comb begin
    if (bus_addr == 20'd0)      bus_rdata = {2'b11, m_num};
    else if (bus_addr == 20'd1) bus_rdata = {5'b10101, m_lvl};
    else                        bus_rdata = vbyte(bus_addr);
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // flags, pc, sp, sw, swnum, num, lvl
  localparam logic [67:0] VECS [5] = '{
    {16'h00C4, 20'h12345, 16'h0800, 1'b0, 6'd0,  6'd5,  3'd3},
    {16'hFFFF, 20'hFFFFF, 16'h0003, 1'b1, 6'd40, 6'd40, 3'd7},
    {16'h0080, 20'h00000, 16'h1000, 1'b1, 6'd31, 6'd31, 3'd0},
    {16'h7F3B, 20'hABCDE, 16'h4000, 1'b1, 6'd63, 6'd63, 3'd5},
    {16'h0000, 20'h54321, 16'hFFFE, 1'b0, 6'd50, 6'd0,  3'd1}
  };

  task automatic run_seq(input logic [15:0] f, input logic [19:0] pc, input logic [15:0] sp,
                         input logic sw, input logic [5:0] swn, input logic [5:0] nm,
                         input logic [2:0] lv, input bit hold);
    logic [15:0] ef, ei;
    logic [19:0] va, epc;
    logic [19:0] wa [4];
    logic [7:0]  wd [4];
    ef = f & ~16'h0044;
    if (!(sw && swn >= 6'd32)) ef = ef & ~16'h0080;
    ei = {ef[15], lv, ef[11:0]};
    va = VB + {12'd0, nm, 2'b00};
    epc = {vbyte(va + 20'd2), vbyte(va + 20'd1), vbyte(va)} & 20'hFFFFF;
    epc = {vbyte(va + 20'd2)[3:0], vbyte(va + 20'd1), vbyte(va)};
    wa[0] = {4'h0, sp - 16'd2}; wd[0] = f[7:0];
    wa[1] = {4'h0, sp - 16'd1}; wd[1] = {f[15:12], pc[19:16]};
    wa[2] = {4'h0, sp - 16'd4}; wd[2] = pc[7:0];
    wa[3] = {4'h0, sp - 16'd3}; wd[3] = pc[15:8];
    @(negedge clk);
    m_num = nm; m_lvl = lv;
    flg_in = f; pc_in = pc; sp_in = sp; sw_int = sw; sw_num = swn; req_valid = 1'b1;
    #1 chk(req_ack === 1'b1, "R1 ack", {31'd0, req_ack}, 32'd1);
    @(posedge clk);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      // R10: scramble inputs while busy
      flg_in = ~f; pc_in = ~pc; sp_in = ~sp; sw_int = ~sw; sw_num = ~swn; req_valid = hold;
      #1;
      chk(req_ack === 1'b0, "R10 no ack while busy", {31'd0, req_ack}, 32'd0);
      chk(done === (k == 19), "R8 done timing", {31'd0, done}, {31'd0, k == 19});
      chk(!(bus_rd && bus_wr), "R9 strobe overlap", {30'd0, bus_rd, bus_wr}, 32'd0);
      case (k)
        0: chk(bus_rd && bus_addr == 20'd0, "R2 info read", bus_addr, 32'd0);
        1: chk(bus_rd && bus_addr == 20'd1, "R2 level read", bus_addr, 32'd1);
        2: begin
          chk(clr_req && clr_num == nm, "R3 clear request", {25'd0, clr_req, clr_num}, {25'd1, nm});
          chk(flg_we && flg_out == ef, "R4 flag clear", {15'd0, flg_we, flg_out}, {15'd1, ef});
        end
        6, 7, 8, 9: chk(bus_wr && bus_addr == wa[k-6] && bus_wdata == wd[k-6], "R5 stack push",
                        {bus_addr, 4'h0, bus_wdata}, {wa[k-6], 4'h0, wd[k-6]});
        12, 13, 14: chk(bus_rd && bus_addr == va + 20'(k - 12), "R6 vector read",
                        bus_addr, va + 20'(k - 12));
        15: chk(flg_we && flg_out == ei, "R7 level load", {15'd0, flg_we, flg_out}, {15'd1, ei});
        19: begin
          chk(pc_we && pc_out == epc, "R8 pc load", {11'd0, pc_we, pc_out}, {11'd1, epc});
          chk(sp_we && sp_out == sp - 16'd4, "R8 sp load", {15'd0, sp_we, sp_out}, {15'd1, sp - 16'd4});
        end
        default: chk(!bus_rd && !bus_wr && !flg_we, "R9 idle cycle",
                     {29'd0, bus_rd, bus_wr, flg_we}, 32'd0);
      endcase
    end
    @(negedge clk);
    #1;
    if (hold) chk(req_ack === 1'b1, "R1 re-accept after done", {31'd0, req_ack}, 32'd1);
    req_valid = 1'b0;
    @(posedge clk);
    if (hold) begin
      for (int k = 0; k < 21; k++) @(posedge clk);
    end
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({req_ack, bus_rd, bus_wr, done, flg_we, pc_we, sp_we, clr_req} == 8'd0,
        "R9 reset idle", 32'd0, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!bus_rd && !bus_wr && !done, "R1 idle without request", {29'd0, bus_rd, bus_wr, done}, 32'd0);
    for (int i = 0; i < 5; i++) begin
      logic [67:0] v;
      v = VECS[i];
      run_seq(v[67:52], v[51:32], v[31:16], v[15], v[14:9], v[8:3], v[2:0], 1'b0);
    end
    // R10: request held high through the whole sequence
    run_seq(16'h00FF, 20'h0BEEF, 16'h0100, 1'b1, 6'd32, 6'd32, 3'd6, 1'b1);
    summary();
  end
endmodule